// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and drives the command bus from reset until the memory is ready for normal traffic. Out of reset, the clock-enable pin stays low and the bus stays idle for a programmable settling interval. The block then raises clock enable and places a short run of idle cycles on the bus. After that it issues the mandatory command chain. Each command occupies exactly one clock and is followed by idle cycles until its minimum gap has elapsed.

The chain has a fixed order. It starts with a precharge of every bank. An extended mode register write comes next; it turns the DLL on and selects the driver strength. A mode register write with the DLL-reset bit set follows, and then a wait long enough for the DLL to lock. After that come a second all-bank precharge and a configurable number of auto refreshes. The chain ends with a mode register write that clears the DLL-reset bit. A sticky ready flag rises once the last write's gap has passed. All timing values are parameters counted in clock cycles. The two mode register images are parameters too.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high and for at least STABLE_CYC cycles after its release, cke is 0, init_done is 0 and the command pins {cs_n,ras_n,cas_n,we_n} show NOP = 4'b0111.
- R2: cke rises once, no more than two cycles after the settling interval, and never falls again before reset. The first non-NOP command appears exactly NOP_CYC cycles after the first cycle with cke high.
- R3: Each command occupies one cycle, and every other cycle after cke rises is NOP. The non-NOP commands appear in this order: precharge-all, extended mode write, mode write with DLL reset, precharge-all, REF_CNT auto refreshes, then the operating mode write.
- R4: The pin codes are precharge = 4'b0010 with addr[10] = 1 and every other address bit 0, auto refresh = 4'b0001, and mode write = 4'b0000. A mode write uses ba = 0 for the mode register and ba = 1 for the extended register. NOP and refresh cycles drive addr = 0 and ba = 0.
- R5: The extended mode write carries EMR_VAL on addr. The first mode write carries MR_VAL with addr[8] forced to 1. The last mode write carries MR_VAL with addr[8] forced to 0.
- R6: Each precharge is followed by exactly T_RP cycles before the next command.
- R7: Each auto refresh is followed by exactly T_RFC cycles before the next command.
- R8: The extended write is followed by exactly T_MRD cycles before the next command. The DLL-reset mode write is followed by exactly max(DLL_LOCK_CYC, T_MRD) cycles before the next command.
- R9: init_done rises exactly T_MRD cycles after the final mode write. It then stays high with cke high and the bus at NOP until reset.
- R10: Asserting reset at any point, including the cycle a command is on the bus, returns the outputs to the R1 state on the next clock. After release the full sequence restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the memory |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus; carries mode images and the all-bank flag |
| ba | output | BA_W | Bank address; selects the mode register target |
| init_done | output | 1 | Sticky flag: initialization finished |

## Verification
Two things can land in the same clock: reset being asserted, and the sequencer placing a command on the bus. The bench waits until the DLL-reset mode write has been logged and raises reset before the following edge. This makes the reset edge coincide with the command slot and its gap countdown. It then checks on the next sample that cke, the ready flag and the bus are back at their reset values. Finally, it checks that a complete sequence with correct order, codes and gaps runs again from the start.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   typedef enum logic [2:0] {
      IC_NOP,
      IC_PREA,
      IC_EMRW,
      IC_MRW_DLL,
      IC_MRW_OP,
      IC_REF
   } init_cmd_e;

   typedef enum logic [3:0] {
      ST_SETTLE,
      ST_CKE_IDLE,
      ST_PREA_1,
      ST_EMRW,
      ST_MRW_DLL,
      ST_PREA_2,
      ST_REFRESH,
      ST_MRW_OP,
      ST_READY
   } init_state_e;

   // pin codes {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] PINS_NOP  = 4'b0111;
   localparam logic [3:0] PINS_PRE  = 4'b0010;
   localparam logic [3:0] PINS_REF  = 4'b0001;
   localparam logic [3:0] PINS_MRW  = 4'b0000;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= CNT_W'(RST_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
   import ddr_init_pkg::*;
#(
   parameter int unsigned STABLE_CYC   = 20000,
   parameter int unsigned NOP_CYC      = 1,
   parameter int unsigned T_RP         = 3,
   parameter int unsigned T_RFC        = 8,
   parameter int unsigned T_MRD        = 2,
   parameter int unsigned DLL_LOCK_CYC = 200,
   parameter int unsigned REF_CNT      = 2
) (
   input  logic      clk,
   input  logic      rst,
   output init_cmd_e cmd,
   output logic      cke_en,
   output logic      ready
);

   localparam int unsigned DLL_GAP = umax(DLL_LOCK_CYC, T_MRD);
   localparam int unsigned MAX_GAP =
      umax(umax(umax(STABLE_CYC, NOP_CYC), umax(T_RP, T_RFC)), umax(T_MRD, DLL_GAP));
   localparam int unsigned CNT_W   = bits_for(MAX_GAP);
   localparam int unsigned RC_W    = bits_for(REF_CNT);

   init_state_e      state_q, state_d;
   logic             first_q;
   logic             t_load;
   logic [CNT_W-1:0] t_val;
   logic             t_done;
   logic [RC_W-1:0]  ref_left_q, ref_left_d;

   ddr_init_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (STABLE_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_done)
   );

   always_comb begin
      state_d    = state_q;
      t_load     = 1'b0;
      t_val      = '0;
      ref_left_d = ref_left_q;
      if (t_done) begin
         unique case (state_q)
            ST_SETTLE: begin
               state_d = ST_CKE_IDLE;
               t_load  = 1'b1;
               t_val   = CNT_W'(NOP_CYC - 1);
            end
            ST_CKE_IDLE: begin
               state_d = ST_PREA_1;
               t_load  = 1'b1;
               t_val   = CNT_W'(T_RP - 1);
            end
            ST_PREA_1: begin
               state_d = ST_EMRW;
               t_load  = 1'b1;
               t_val   = CNT_W'(T_MRD - 1);
            end
            ST_EMRW: begin
               state_d = ST_MRW_DLL;
               t_load  = 1'b1;
               t_val   = CNT_W'(DLL_GAP - 1);
            end
            ST_MRW_DLL: begin
               state_d = ST_PREA_2;
               t_load  = 1'b1;
               t_val   = CNT_W'(T_RP - 1);
            end
            ST_PREA_2: begin
               state_d    = ST_REFRESH;
               t_load     = 1'b1;
               t_val      = CNT_W'(T_RFC - 1);
               ref_left_d = RC_W'(REF_CNT);
            end
            ST_REFRESH: begin
               t_load = 1'b1;
               if (ref_left_q > RC_W'(1)) begin
                  state_d    = ST_REFRESH;
                  t_val      = CNT_W'(T_RFC - 1);
                  ref_left_d = ref_left_q - 1'b1;
               end else begin
                  state_d = ST_MRW_OP;
                  t_val   = CNT_W'(T_MRD - 1);
               end
            end
            ST_MRW_OP: begin
               state_d = ST_READY;
            end
            default: begin
               state_d = ST_READY;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= ST_SETTLE;
         first_q    <= 1'b0;
         ref_left_q <= '0;
      end else begin
         state_q    <= state_d;
         first_q    <= t_load;
         ref_left_q <= ref_left_d;
      end
   end

   always_comb begin
      cmd = IC_NOP;
      if (first_q) begin
         unique case (state_q)
            ST_PREA_1, ST_PREA_2: cmd = IC_PREA;
            ST_EMRW:              cmd = IC_EMRW;
            ST_MRW_DLL:           cmd = IC_MRW_DLL;
            ST_REFRESH:           cmd = IC_REF;
            ST_MRW_OP:            cmd = IC_MRW_OP;
            default:              cmd = IC_NOP;
         endcase
      end
   end

   assign cke_en = (state_q != ST_SETTLE);
   assign ready  = (state_q == ST_READY);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
   import ddr_init_pkg::*;
#(
   parameter int unsigned ADDR_W      = 13,
   parameter int unsigned BA_W        = 2,
   parameter logic [ADDR_W-1:0] EMR_VAL = '0,
   parameter logic [ADDR_W-1:0] MR_VAL  = '0,
   parameter int unsigned DLL_RST_BIT = 8,
   parameter int unsigned AP_BIT      = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  init_cmd_e         cmd,
   input  logic              cke_en,
   input  logic              ready,
   output logic              cke,
   output logic [3:0]        pins,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              init_done
);

   localparam logic [BA_W-1:0] BA_MR  = '0;
   localparam logic [BA_W-1:0] BA_EMR = BA_W'(1);

   logic [ADDR_W-1:0] prea_img;
   logic [ADDR_W-1:0] mrw_dll_img;
   logic [ADDR_W-1:0] mrw_op_img;

   // per-bit address images for the fixed commands
   for (genvar b = 0; b < ADDR_W; b++) begin : g_img
      if (b == AP_BIT) begin : g_ap
         assign prea_img[b] = 1'b1;
      end else begin : g_nap
         assign prea_img[b] = 1'b0;
      end
      if (b == DLL_RST_BIT) begin : g_dll
         assign mrw_dll_img[b] = 1'b1;
         assign mrw_op_img[b]  = 1'b0;
      end else begin : g_mr
         assign mrw_dll_img[b] = MR_VAL[b];
         assign mrw_op_img[b]  = MR_VAL[b];
      end
   end

   logic [3:0]        pins_d;
   logic [ADDR_W-1:0] addr_d;
   logic [BA_W-1:0]   ba_d;

   always_comb begin
      pins_d = PINS_NOP;
      addr_d = '0;
      ba_d   = '0;
      unique case (cmd)
         IC_PREA: begin
            pins_d = PINS_PRE;
            addr_d = prea_img;
         end
         IC_EMRW: begin
            pins_d = PINS_MRW;
            addr_d = EMR_VAL;
            ba_d   = BA_EMR;
         end
         IC_MRW_DLL: begin
            pins_d = PINS_MRW;
            addr_d = mrw_dll_img;
            ba_d   = BA_MR;
         end
         IC_MRW_OP: begin
            pins_d = PINS_MRW;
            addr_d = mrw_op_img;
            ba_d   = BA_MR;
         end
         IC_REF: begin
            pins_d = PINS_REF;
         end
         default: begin
            pins_d = PINS_NOP;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cke       <= 1'b0;
         pins      <= PINS_NOP;
         addr      <= '0;
         ba        <= '0;
         init_done <= 1'b0;
      end else begin
         cke       <= cke_en;
         pins      <= pins_d;
         addr      <= addr_d;
         ba        <= ba_d;
         init_done <= ready;
      end
   end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int unsigned ADDR_W       = 13,
   parameter int unsigned BA_W         = 2,
   parameter int unsigned STABLE_CYC   = 20000,
   parameter int unsigned NOP_CYC      = 1,
   parameter int unsigned T_RP         = 3,
   parameter int unsigned T_RFC        = 8,
   parameter int unsigned T_MRD        = 2,
   parameter int unsigned DLL_LOCK_CYC = 200,
   parameter int unsigned REF_CNT      = 2,
   parameter logic [ADDR_W-1:0] EMR_VAL = ADDR_W'(2),
   parameter logic [ADDR_W-1:0] MR_VAL  = ADDR_W'(50)
) (
   input  logic              clk,
   input  logic              rst,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              init_done
);

   localparam int unsigned DLL_RST_BIT = 8;
   localparam int unsigned AP_BIT      = 10;

   // elaboration-time parameter checks
   if (ADDR_W <= AP_BIT) begin : g_chk_addr
      $error("ddr_init_seq: ADDR_W must exceed the all-bank bit position");
   end
   if (BA_W < 1) begin : g_chk_ba
      $error("ddr_init_seq: BA_W must be at least 1");
   end
   if (STABLE_CYC < 1 || NOP_CYC < 1) begin : g_chk_settle
      $error("ddr_init_seq: STABLE_CYC and NOP_CYC must be at least 1");
   end
   if (T_RP < 2 || T_RFC < 2 || T_MRD < 2) begin : g_chk_gap
      $error("ddr_init_seq: command gaps must be at least 2 cycles");
   end
   if (REF_CNT < 2) begin : g_chk_ref
      $error("ddr_init_seq: at least two refreshes are required");
   end

   init_cmd_e  cmd;
   logic       cke_en;
   logic       ready;
   logic [3:0] pins;

   ddr_init_fsm #(
      .STABLE_CYC   (STABLE_CYC),
      .NOP_CYC      (NOP_CYC),
      .T_RP         (T_RP),
      .T_RFC        (T_RFC),
      .T_MRD        (T_MRD),
      .DLL_LOCK_CYC (DLL_LOCK_CYC),
      .REF_CNT      (REF_CNT)
   ) u_fsm (
      .clk    (clk),
      .rst    (rst),
      .cmd    (cmd),
      .cke_en (cke_en),
      .ready  (ready)
   );

   ddr_init_cmd_enc #(
      .ADDR_W      (ADDR_W),
      .BA_W        (BA_W),
      .EMR_VAL     (EMR_VAL),
      .MR_VAL      (MR_VAL),
      .DLL_RST_BIT (DLL_RST_BIT),
      .AP_BIT      (AP_BIT)
   ) u_enc (
      .clk       (clk),
      .rst       (rst),
      .cmd       (cmd),
      .cke_en    (cke_en),
      .ready     (ready),
      .cke       (cke),
      .pins      (pins),
      .addr      (addr),
      .ba        (ba),
      .init_done (init_done)
   );

   assign cs_n  = pins[3];
   assign ras_n = pins[2];
   assign cas_n = pins[1];
   assign we_n  = pins[0];

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
   parameter int unsigned ADDR_W       = 13,
   parameter int unsigned BA_W         = 2,
   parameter int unsigned DLL_LOCK_CYC = 200
) (
   input logic              clk,
   input logic              rst,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic [BA_W-1:0]   ba,
   input logic              init_done
);

   logic [3:0] pins;
   assign pins = {cs_n, ras_n, cas_n, we_n};

   logic       is_cmd;
   assign is_cmd = (pins != 4'b0111);

   // cycles since the DLL-reset mode write, saturating
   logic        dll_armed;
   logic [15:0] dll_cnt;
   always_ff @(posedge clk) begin
      if (rst) begin
         dll_armed <= 1'b0;
         dll_cnt   <= '0;
      end else if (pins == 4'b0000 && ba == '0 && addr[8]) begin
         dll_armed <= 1'b1;
         dll_cnt   <= 16'd1;
      end else if (dll_armed && is_cmd) begin
         dll_armed <= 1'b0;
      end else if (dll_armed && dll_cnt != 16'hFFFF) begin
         dll_cnt <= dll_cnt + 1'b1;
      end
   end

   a_r1_idle_while_cke_low: assert property (@(posedge clk) disable iff (rst)
      !cke |-> !is_cmd);

   a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (rst)
      cke |=> cke);

   a_r3_single_cycle_cmd: assert property (@(posedge clk) disable iff (rst)
      is_cmd |=> !is_cmd);

   a_r4_prea_all_banks: assert property (@(posedge clk) disable iff (rst)
      (pins == 4'b0010) |-> addr[10]);

   a_r4_mrw_target: assert property (@(posedge clk) disable iff (rst)
      (pins == 4'b0000) |-> (ba == BA_W'(0) || ba == BA_W'(1)));

   a_r8_dll_lock_wait: assert property (@(posedge clk) disable iff (rst)
      (dll_armed && is_cmd) |-> (dll_cnt >= 16'(DLL_LOCK_CYC)));

   a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   a_r9_done_bus_idle: assert property (@(posedge clk) disable iff (rst)
      init_done |-> (cke && !is_cmd));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
   .ADDR_W       (ADDR_W),
   .BA_W         (BA_W),
   .DLL_LOCK_CYC (DLL_LOCK_CYC)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cke       (cke),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .addr      (addr),
   .ba        (ba),
   .init_done (init_done)
);

// File: tb/ddr_init_seq_tb.sv
`timescale 1ns/1ps
module ddr_init_seq_tb;

   localparam int unsigned ADDR_W   = 13;
   localparam int unsigned BA_W     = 2;
   localparam int unsigned STABLE   = 40;
   localparam int unsigned NOPC     = 1;
   localparam int unsigned TRP      = 3;
   localparam int unsigned TRFC     = 7;
   localparam int unsigned TMRD     = 2;
   localparam int unsigned DLL      = 200;
   localparam int unsigned NREF     = 3;
   localparam logic [12:0] EMR      = 13'h0002;
   localparam logic [12:0] MR       = 13'h0032;
   localparam int unsigned DLLGAP   = (DLL > TMRD) ? DLL : TMRD;
   localparam int          NCMD     = 5 + NREF;

   // {pins[3:0], ba[1:0], addr[12:0], gap_to_next[15:0]}
   localparam logic [34:0] EXP [NCMD] = '{
      {4'b0010, 2'd0, 13'h0400,          16'(TRP)},
      {4'b0000, 2'd1, EMR,               16'(TMRD)},
      {4'b0000, 2'd0, MR | 13'h0100,     16'(DLLGAP)},
      {4'b0010, 2'd0, 13'h0400,          16'(TRP)},
      {4'b0001, 2'd0, 13'h0000,          16'(TRFC)},
      {4'b0001, 2'd0, 13'h0000,          16'(TRFC)},
      {4'b0001, 2'd0, 13'h0000,          16'(TRFC)},
      {4'b0000, 2'd0, MR & ~13'h0100,    16'(TMRD)}
   };

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              cke, cs_n, ras_n, cas_n, we_n, init_done;
   logic [ADDR_W-1:0] addr;
   logic [BA_W-1:0]   ba;

   always #5 clk = ~clk;

   ddr_init_seq #(
      .ADDR_W (ADDR_W), .BA_W (BA_W), .STABLE_CYC (STABLE), .NOP_CYC (NOPC),
      .T_RP (TRP), .T_RFC (TRFC), .T_MRD (TMRD), .DLL_LOCK_CYC (DLL),
      .REF_CNT (NREF), .EMR_VAL (EMR), .MR_VAL (MR)
   ) u_dut (
      .clk (clk), .rst (rst), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
      .cas_n (cas_n), .we_n (we_n), .addr (addr), .ba (ba), .init_done (init_done)
   );

   // bus monitor, sampled on the falling edge
   logic [3:0]  pins;
   assign pins = {cs_n, ras_n, cas_n, we_n};

   int          cyc, n_cmd, cke_cyc, done_cyc, cke_drops, bad_low;
   logic [3:0]  log_pins [16];
   logic [1:0]  log_ba   [16];
   logic [12:0] log_addr [16];
   int          log_cyc  [16];

   always @(negedge clk) begin
      if (rst) begin
         cyc = 0; n_cmd = 0; cke_cyc = 0; done_cyc = 0; cke_drops = 0; bad_low = 0;
      end else begin
         cyc = cyc + 1;
         if (cke && cke_cyc == 0) cke_cyc = cyc;
         if (!cke && cke_cyc != 0) cke_drops = cke_drops + 1;
         if (!cke && pins != 4'b0111) bad_low = bad_low + 1;
         if (init_done && done_cyc == 0) done_cyc = cyc;
         if (pins != 4'b0111) begin
            if (n_cmd < 16) begin
               log_pins[n_cmd] = pins;
               log_ba[n_cmd]   = ba;
               log_addr[n_cmd] = addr;
               log_cyc[n_cmd]  = cyc;
            end
            n_cmd = n_cmd + 1;
         end
      end
   end

   int n_total = 0;
   int n_pass  = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_total++;
      if (ok) n_pass++;
      else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
   endtask

   task automatic apply_reset();
      @(posedge clk); #2 rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk(cke == 1'b0,      "R1 cke in reset",  cke, 0);
      chk(pins == 4'b0111,  "R1 NOP in reset",  pins, 7);
      chk(init_done == 1'b0,"R1 done in reset", init_done, 0);
      @(posedge clk); #2 rst = 1'b0;
   endtask

   task automatic wait_done();
      int guard = 0;
      while (!init_done && guard < 5000) begin
         @(negedge clk); #1;
         guard++;
      end
      chk(init_done == 1'b1, "R9 watchdog: init_done reached", guard, 5000);
   endtask

   task automatic check_sequence();
      chk(n_cmd == NCMD, "R3 command count", n_cmd, NCMD);
      chk(cke_cyc - 1 >= int'(STABLE), "R1 cke low span", cke_cyc - 1, STABLE);
      chk(cke_cyc - 1 <= int'(STABLE) + 2, "R2 cke rise bound", cke_cyc - 1, STABLE + 2);
      chk(bad_low == 0, "R1 command while cke low", bad_low, 0);
      chk(log_cyc[0] - cke_cyc == int'(NOPC), "R2 idle before first command",
          log_cyc[0] - cke_cyc, NOPC);
      for (int i = 0; i < NCMD && i < n_cmd; i++) begin
         int gap_act;
         int gap_exp;
         chk(log_pins[i] == EXP[i][34:31], $sformatf("R3 R4 pins of command %0d", i),
             log_pins[i], EXP[i][34:31]);
         chk(log_ba[i] == EXP[i][30:29], $sformatf("R4 ba of command %0d", i),
             log_ba[i], EXP[i][30:29]);
         chk(log_addr[i] == EXP[i][28:16], $sformatf("R5 addr of command %0d", i),
             log_addr[i], EXP[i][28:16]);
         gap_exp = int'(EXP[i][15:0]);
         gap_act = (i == NCMD - 1) ? (done_cyc - log_cyc[i]) : (log_cyc[i+1] - log_cyc[i]);
         if (EXP[i][34:31] == 4'b0010)
            chk(gap_act == gap_exp, $sformatf("R6 gap after precharge %0d", i), gap_act, gap_exp);
         else if (EXP[i][34:31] == 4'b0001)
            chk(gap_act == gap_exp, $sformatf("R7 gap after refresh %0d", i), gap_act, gap_exp);
         else if (i == NCMD - 1)
            chk(gap_act == gap_exp, "R9 done delay after final mode write", gap_act, gap_exp);
         else
            chk(gap_act == gap_exp, $sformatf("R8 gap after mode write %0d", i), gap_act, gap_exp);
      end
   endtask

   initial begin
      // run 1: full sequence
      apply_reset();
      wait_done();
      check_sequence();
      repeat (30) @(negedge clk);
      #1;
      chk(init_done == 1'b1, "R9 done held", init_done, 1);
      chk(cke == 1'b1 && cke_drops == 0, "R2 cke held high", cke_drops, 0);
      chk(n_cmd == NCMD, "R9 no command after done", n_cmd, NCMD);
      chk(pins == 4'b0111, "R9 bus idle after done", pins, 7);

      // run 2: reset lands on the edge after the DLL-reset mode write
      apply_reset();
      begin
         int guard = 0;
         while (n_cmd < 3 && guard < 2000) begin
            @(negedge clk); #1;
            guard++;
         end
         chk(n_cmd == 3, "R10 reached DLL-reset write", n_cmd, 3);
      end
      rst = 1'b1;
      @(negedge clk); #1;
      chk(cke == 1'b0, "R10 cke cleared by reset", cke, 0);
      chk(pins == 4'b0111, "R10 bus NOP after reset", pins, 7);
      chk(init_done == 1'b0, "R10 done cleared", init_done, 0);
      @(posedge clk); #2 rst = 1'b0;
      wait_done();
      check_sequence();

      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

   // watchdog: ends a hung run with a failure and the summary
   initial begin
      #1500000;
      chk(1'b0, "R9 watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

endmodule